// File: doc/BRIEF.md
# DDR Row-Miss Cache-Line Read Sequencer

This block is the read engine of a memory controller that drives a single, non-interleaved double-data-rate DRAM with a 64-bit data path. Each read fetches one 64-byte cache line. The block treats every line read as a row miss. It precharges the open row, activates the target row, and then issues column reads for the line. Each column read carries two doublewords, because the DRAM transfers on both clock edges. Four column cycles therefore move all eight doublewords.

The read command arrives on a valid/ready handshake. The block raises ready only while it is idle, and a requester holds `cmd_valid` until the block accepts it. The cycle in which the command is accepted counts as the controller's start-up overhead cycle. Each pair of doublewords is registered once and then placed on the processor-side stream. The last pair appears seven cycles after the accept cycle. The processor-side stream has a valid but no ready, because DRAM data cannot be stalled, so the consumer must take every beat in the cycle it is presented. Refresh, writes and bank interleaving are not handled.

Top module: `ddr_rowmiss_rd`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle, and `busy` is its inverse. A command is accepted on a rising edge where both `cmd_valid` and `cmd_ready` are high, and `busy` stays high from the next cycle until the sequence ends.
- R2: In the cycle after acceptance, `dram_pre` is high and `dram_act` and `dram_rd` are low.
- R3: In the following cycle, `dram_act` is high and `dram_row` equals `cmd_addr[31:6]` of the accepted command.
- R4: In the next four consecutive cycles, `dram_rd` is high and `dram_col` (the doubleword index within the line) takes the values 0, 2, 4 and 6 in that order. `dram_row` is held at the activated row throughout.
- R5: In no cycle are two or more of `dram_pre`, `dram_act` and `dram_rd` high together.
- R6: `dram_rdata` is sampled at the end of each column-read cycle. Bits [63:0] carry the doubleword at `dram_col`, and bits [127:64] carry the doubleword at `dram_col`+1. In the cycle after sampling, the same value appears on `out_data` with `out_valid` high, so the line leaves the block in ascending address order.
- R7: `out_last` is high with the fourth beat only. That beat occupies the seventh cycle after the accept cycle. In that same cycle `busy` is low and `cmd_ready` is high, so successive commands can be accepted seven cycles apart.
- R8: The block ignores `cmd_valid` while it is busy, and it ignores `cmd_addr[5:0]`: every line read starts at doubleword 0.
- R9: After reset the block is idle: `busy` is 0, `cmd_ready` is 1, all DRAM command outputs are 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read command request |
| cmd_ready | output | 1 | Block can accept a command (idle) |
| cmd_addr | input | 32 | Byte address of the cache line |
| busy | output | 1 | A line read is in progress |
| dram_pre | output | 1 | Precharge command |
| dram_act | output | 1 | Row activate command |
| dram_rd | output | 1 | Column read command |
| dram_row | output | 26 | Row address for activate and column reads |
| dram_col | output | 3 | Doubleword column of the first word of the pair |
| dram_rdata | input | 128 | Two doublewords per cycle from the DRAM (low half first) |
| out_valid | output | 1 | Processor-side beat valid |
| out_data | output | 128 | Two doublewords, lower address in bits [63:0] |
| out_last | output | 1 | Final beat of the line |

## Verification
The in-line assertions check the local ordering on every cycle. That covers the one-hot DRAM commands, precharge following acceptance, activate following precharge, a first column of 0 after activate, a stable row during column reads, output beats occurring only after a column read, and `busy` being low on the final beat. Other properties can only be shown by the bench's sweep, which computes expected values from the command address: the exact seven-cycle schedule, the row and column values, the data pairing and its order, that commands arriving while busy leave no trace, and that offset bits are discarded.

// File: rtl/ddr_rm_pkg.sv
package ddr_rm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2,
    ST_COL  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ddr_rm_fsm.sv
module ddr_rm_fsm
  import ddr_rm_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              idle,
  output logic              pre,
  output logic              act,
  output logic              rd,
  output logic              rd_last,
  output logic [BEAT_W-1:0] beat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_PRE;
        ST_PRE:  state <= ST_ACT;
        ST_ACT: begin
          state <= ST_COL;
          beat  <= '0;
        end
        ST_COL: begin
          if (beat == LAST_BEAT) state <= ST_IDLE;
          else                   beat  <= beat + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (state == ST_IDLE);
  assign pre     = (state == ST_PRE);
  assign act     = (state == ST_ACT);
  assign rd      = (state == ST_COL);
  assign rd_last = rd && (beat == LAST_BEAT);

  // R4: a column burst never ends early
  a_r4_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !rd_last) |=> rd);
endmodule

// File: rtl/ddr_rm_addr.sv
module ddr_rm_addr #(
  parameter int ROW_W  = 26,
  parameter int BEAT_W = 2,
  parameter int COL_W  = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [BEAT_W-1:0] beat,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (load) row <= row_in;
  end

  // one column read per doubleword pair: even doubleword index
  assign col = {beat, 1'b0};
endmodule

// File: rtl/ddr_rm_pipe.sv
module ddr_rm_pipe #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         last_in,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic         last,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      last  <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= en;
      last  <= en && last_in;
      if (en) dout <= din;
    end
  end

  // R7: the final marker only rides on a valid beat
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);
endmodule

// File: rtl/ddr_rowmiss_rd.sv
module ddr_rowmiss_rd #(
  parameter int ADDR_W     = 32,
  parameter int DQ_W       = 64,
  parameter int LINE_BYTES = 64,
  localparam int WORD_BYTES = DQ_W / 8,
  localparam int WORDS      = LINE_BYTES / WORD_BYTES,
  localparam int BEATS      = WORDS / 2,
  localparam int OFS_W      = $clog2(LINE_BYTES),
  localparam int ROW_W      = ADDR_W - OFS_W,
  localparam int COL_W      = $clog2(WORDS),
  localparam int BEAT_W     = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              dram_pre,
  output logic              dram_act,
  output logic              dram_rd,
  output logic [ROW_W-1:0]  dram_row,
  output logic [COL_W-1:0]  dram_col,
  input  logic [2*DQ_W-1:0] dram_rdata,
  output logic              out_valid,
  output logic [2*DQ_W-1:0] out_data,
  output logic              out_last
);
  logic              idle, rd_last, accept;
  logic [BEAT_W-1:0] beat;
  logic              unused_ofs;

  assign unused_ofs = ^cmd_addr[OFS_W-1:0];
  assign accept     = cmd_valid && idle;
  assign cmd_ready  = idle;
  assign busy       = !idle;

  ddr_rm_fsm #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .idle(idle),
    .pre(dram_pre), .act(dram_act), .rd(dram_rd), .rd_last(rd_last), .beat(beat)
  );

  ddr_rm_addr #(.ROW_W(ROW_W), .BEAT_W(BEAT_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .row_in(cmd_addr[ADDR_W-1:OFS_W]),
    .beat(beat), .row(dram_row), .col(dram_col)
  );

  ddr_rm_pipe #(.W(2*DQ_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(dram_rd), .last_in(rd_last), .din(dram_rdata),
    .valid(out_valid), .last(out_last), .dout(out_data)
  );

  a_r5_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_pre, dram_act, dram_rd}));
  a_r2_pre_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> dram_pre);
  a_r3_act_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    dram_pre |=> dram_act);
  a_r4_first_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dram_act |=> (dram_rd && dram_col == '0));
  a_r4_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    dram_rd |-> $stable(dram_row));
  a_r6_beat_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(dram_rd));
  a_r1_busy_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_pre || dram_act || dram_rd) |-> busy);
  a_r7_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> !busy);
endmodule

// File: tb/ddr_rowmiss_rd_test.sv
module ddr_rowmiss_rd_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_addr = '0;
  logic         busy, dram_pre, dram_act, dram_rd;
  logic [25:0]  dram_row;
  logic [2:0]   dram_col;
  logic [127:0] dram_rdata = '0;
  logic         out_valid, out_last;
  logic [127:0] out_data;

  int  vectors = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  ddr_rowmiss_rd uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .busy(busy), .dram_pre(dram_pre), .dram_act(dram_act),
    .dram_rd(dram_rd), .dram_row(dram_row), .dram_col(dram_col),
    .dram_rdata(dram_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

  function automatic logic [63:0] dw(input logic [25:0] row, input int c);
    return {6'h2A, row, 32'(c) ^ 32'h5EED_0000};
  endfunction

  // DRAM model: returns the addressed doubleword pair during a column read
  always @(negedge clk) begin
    if (dram_rd) dram_rdata <= {dw(dram_row, int'(dram_col) + 1), dw(dram_row, int'(dram_col))};
    else         dram_rdata <= '0;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [31:0] addr, input bit poke);
    logic [25:0] row;
    row = addr[31:6];
    cmd_valid = 1'b1;
    cmd_addr  = addr;
    check("R1 ready when idle", 128'(cmd_ready), 128'(1));
    for (int k = 0; k < 7; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) begin
        if (poke) cmd_addr = ~addr;
        else cmd_valid = 1'b0;
      end
      if (k == 5) cmd_valid = 1'b0;
      check("R1 busy", 128'(busy), 128'(k < 6));
      check("R2/R3/R4/R5 cmd pins", 128'({dram_pre, dram_act, dram_rd}),
            128'({k == 0, k == 1, (k >= 2 && k <= 5)}));
      if (k >= 1 && k <= 5) check("R3 row", 128'(dram_row), 128'(row));
      if (k >= 2 && k <= 5) check("R4 col", 128'(dram_col), 128'(2 * (k - 2)));
      check("R6 out_valid", 128'(out_valid), 128'(k >= 3));
      if (k >= 3) begin
        int b;
        b = k - 3;
        check("R6 data", out_data, {dw(row, 2 * b + 1), dw(row, 2 * b)});
        check("R7 last", 128'(out_last), 128'(k == 6));
      end
      if (k == 6) check("R7 ready on last beat", 128'(cmd_ready), 128'(1));
    end
    if (poke) begin
      @(posedge clk);
      @(negedge clk);
      check("R8 busy poke ignored", 128'({busy, dram_pre, out_valid}), 128'(0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset busy/ready", 128'({busy, cmd_ready}), 128'(2'b01));
    check("R9 reset cmds", 128'({dram_pre, dram_act, dram_rd, out_valid}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", 128'({busy, dram_pre, out_valid}), 128'(0));
    run_cmd(32'h0000_0000, 1'b0);
    run_cmd(32'hFFFF_FFFF, 1'b1);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a = ((32'(i) * 32'h0123_4567) ^ (32'(i) << 20)) & 32'hFFFF_FFC0;
      a = a | 32'(i % 64); // R8: offset bits vary, must be ignored
      run_cmd(a, (i % 5) == 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule